// File: doc/BRIEF.md
# Calibrated Measurement Correction Unit

This unit turns raw signed converter codes into calibrated values for a battery monitor. Each sample arrives with a channel tag and a valid strobe. The unit looks up the offset and gain for that channel in a bank of calibration inputs. It subtracts the offset and multiplies by the gain. It then divides by 2^14, so a gain of 16384 is unity, and clamps the result to the 16-bit signed range.

Two channels get extra treatment after scaling. A current result whose magnitude is below a programmable dead band is forced to zero. A pack voltage result gets a resistive-drop term added. That term is the most recent current result times a 16-bit resistance word, divided by 65535.

The unit is a three-stage pipeline. It accepts one sample per clock. Results come out in the order the samples went in.

Top module: `meas_corrector`

## Requirements
- R1: While `rst` is high and on the first clock after it, `out_valid` is low. The held current value used for the pack drop resets to zero, so a pack sample taken before any current sample gets no drop term.
- R2: A sample taken with `in_valid` high appears on `out_value` with `out_valid` high exactly 3 clocks later. Samples come out in order, one per clock at most, and `out_chan` repeats the input tag. Tag codes: 0 current, 1 pack voltage, 2 to 5 cells 1 to 4, 6 internal temperature, 7 external temperature.
- R3: For the current and pack channels, the scaled value is floor((raw − offset) × gain / 16384), using that channel's own offset and unsigned gain. The division is an arithmetic right shift by 14, so it rounds toward negative infinity.
- R4: Any result above 32767 is output as 32767, and any result below −32768 is output as −32768.
- R5: A current result v with −band < v < band is output as 0. Here band is the unsigned `cal_null_band`. A result whose magnitude equals band is passed through unchanged.
- R6: All four cell channels use the single offset `cal_cell_off`. Cell k (k = 1..4) uses the gain in `cal_cell_gain[(k-1)*16 +: 16]`.
- R7: The internal and external temperature channels each use their own offset and gain pair in the R3 formula.
- R8: The pack result is saturate(scaled pack + (I × `cal_pack_res`) / 65535). I is the most recent current result already output, after the dead band. The division truncates toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw sample strobe |
| in_chan | input | 3 | Channel tag of the sample |
| in_raw | input | 16 | Signed raw converter code |
| cal_cur_off | input | 16 | Signed current offset |
| cal_cur_gain | input | 16 | Unsigned current gain (16384 = 1.0) |
| cal_pack_off | input | 16 | Signed pack voltage offset |
| cal_pack_gain | input | 16 | Unsigned pack voltage gain |
| cal_cell_off | input | 16 | Signed offset shared by all cells |
| cal_cell_gain | input | 64 | Four unsigned cell gains, cell 1 in the low 16 bits |
| cal_tint_off | input | 16 | Signed internal temperature offset |
| cal_tint_gain | input | 16 | Unsigned internal temperature gain |
| cal_text_off | input | 16 | Signed external temperature offset |
| cal_text_gain | input | 16 | Unsigned external temperature gain |
| cal_null_band | input | 16 | Unsigned zero-current band |
| cal_pack_res | input | 16 | Unsigned pack resistance word (scaled by 1/65535) |
| out_valid | output | 1 | Result strobe |
| out_chan | output | 3 | Channel tag of the result |
| out_value | output | 16 | Signed calibrated result |

## Verification
The bench uses an odd negative offset-corrected product with a half gain. A design that truncated instead of flooring would return −3 where −4 is expected. It steps a current across the dead-band edge at band−1, band, −band and −(band−1). An off-by-one compare would zero or pass the wrong pair. It drives large gains in both directions. A missing clamp would wrap the sign. It sends a pack sample right after a negative current in a back-to-back stream. A design that read the current from the wrong pipeline stage, or floored the drop division, would report a drop differing by one or more counts.

// File: rtl/meas_corr_pkg.sv
package meas_corr_pkg;
  typedef enum logic [2:0] {
    CH_CUR   = 3'd0,
    CH_PACK  = 3'd1,
    CH_CELL1 = 3'd2,
    CH_CELL2 = 3'd3,
    CH_CELL3 = 3'd4,
    CH_CELL4 = 3'd5,
    CH_TINT  = 3'd6,
    CH_TEXT  = 3'd7
  } chan_e;

  localparam int GAIN_SHIFT = 14;
  localparam int RES_DIVISOR = 65535;
endpackage

// File: rtl/mc_offset_stage.sv
module mc_offset_stage
  import meas_corr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16,
  parameter int NCELL  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [2:0]                in_chan,
  input  logic [DATA_W-1:0]         in_raw,
  input  logic [DATA_W-1:0]         cal_cur_off,
  input  logic [GAIN_W-1:0]         cal_cur_gain,
  input  logic [DATA_W-1:0]         cal_pack_off,
  input  logic [GAIN_W-1:0]         cal_pack_gain,
  input  logic [DATA_W-1:0]         cal_cell_off,
  input  logic [NCELL*GAIN_W-1:0]   cal_cell_gain,
  input  logic [DATA_W-1:0]         cal_tint_off,
  input  logic [GAIN_W-1:0]         cal_tint_gain,
  input  logic [DATA_W-1:0]         cal_text_off,
  input  logic [GAIN_W-1:0]         cal_text_gain,
  output logic                      s1_valid,
  output logic [2:0]                s1_chan,
  output logic signed [DATA_W:0]    s1_diff,
  output logic [GAIN_W-1:0]         s1_gain
);
  logic [GAIN_W-1:0] cell_g [NCELL];
  logic [DATA_W-1:0] sel_off;
  logic [GAIN_W-1:0] sel_gain;
  logic [GAIN_W-1:0] cell_sel;

  for (genvar k = 0; k < NCELL; k++) begin : g_cell_unpack
    assign cell_g[k] = cal_cell_gain[k*GAIN_W +: GAIN_W];
  end

  always_comb begin
    cell_sel = '0;
    for (int k = 0; k < NCELL; k++) begin
      if (in_chan == 3'(int'(CH_CELL1) + k)) cell_sel = cell_g[k];
    end
  end

  always_comb begin
    case (chan_e'(in_chan))
      CH_CUR:  begin sel_off = cal_cur_off;  sel_gain = cal_cur_gain;  end
      CH_PACK: begin sel_off = cal_pack_off; sel_gain = cal_pack_gain; end
      CH_TINT: begin sel_off = cal_tint_off; sel_gain = cal_tint_gain; end
      CH_TEXT: begin sel_off = cal_text_off; sel_gain = cal_text_gain; end
      default: begin sel_off = cal_cell_off; sel_gain = cell_sel;      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_chan  <= '0;
      s1_diff  <= '0;
      s1_gain  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_chan  <= in_chan;
      s1_diff  <= $signed({in_raw[DATA_W-1], in_raw}) -
                  $signed({sel_off[DATA_W-1], sel_off});
      s1_gain  <= sel_gain;
    end
  end
endmodule

// File: rtl/mc_scale_stage.sv
module mc_scale_stage
  import meas_corr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      s1_valid,
  input  logic [2:0]                s1_chan,
  input  logic signed [DATA_W:0]    s1_diff,
  input  logic [GAIN_W-1:0]         s1_gain,
  output logic                      s2_valid,
  output logic [2:0]                s2_chan,
  output logic signed [DATA_W-1:0]  s2_value
);
  localparam int PROD_W = DATA_W + GAIN_W + 2;
  localparam logic signed [PROD_W-1:0] MAXV =
    $signed({{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
  localparam logic signed [PROD_W-1:0] MINV = ~MAXV;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;
  logic signed [DATA_W-1:0] clamped;

  always_comb begin
    prod    = s1_diff * $signed({1'b0, s1_gain});
    shifted = prod >>> GAIN_SHIFT;
    if (shifted > MAXV)      clamped = MAXV[DATA_W-1:0];
    else if (shifted < MINV) clamped = MINV[DATA_W-1:0];
    else                     clamped = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_chan  <= '0;
      s2_value <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_chan  <= s1_chan;
      s2_value <= clamped;
    end
  end
endmodule

// File: rtl/mc_post_stage.sv
module mc_post_stage
  import meas_corr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RES_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      s2_valid,
  input  logic [2:0]                s2_chan,
  input  logic signed [DATA_W-1:0]  s2_value,
  input  logic [DATA_W-1:0]         cal_null_band,
  input  logic [RES_W-1:0]          cal_pack_res,
  output logic                      out_valid,
  output logic [2:0]                out_chan,
  output logic [DATA_W-1:0]         out_value
);
  localparam int PR_W = DATA_W + RES_W + 1;
  localparam logic signed [PR_W-1:0] DIV_S = PR_W'(RES_DIVISOR);
  localparam logic signed [PR_W-1:0] MAXV =
    $signed({{(PR_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
  localparam logic signed [PR_W-1:0] MINV = ~MAXV;

  logic signed [DATA_W-1:0] last_cur;
  logic signed [DATA_W:0]   v_ext;
  logic signed [DATA_W:0]   band_ext;
  logic                     in_band;
  logic signed [DATA_W-1:0] cur_res;
  logic signed [PR_W-1:0]   drop_prod;
  logic signed [PR_W-1:0]   drop;
  logic signed [PR_W-1:0]   pack_sum;
  logic signed [DATA_W-1:0] pack_res;
  logic signed [DATA_W-1:0] result;

  always_comb begin
    v_ext    = {s2_value[DATA_W-1], s2_value};
    band_ext = $signed({1'b0, cal_null_band});
    in_band  = (v_ext < band_ext) && (v_ext > -band_ext);
    cur_res  = in_band ? '0 : s2_value;
  end

  always_comb begin
    drop_prod = last_cur * $signed({1'b0, cal_pack_res});
    drop      = drop_prod / DIV_S;
    pack_sum  = PR_W'(s2_value) + drop;
    if (pack_sum > MAXV)      pack_res = MAXV[DATA_W-1:0];
    else if (pack_sum < MINV) pack_res = MINV[DATA_W-1:0];
    else                      pack_res = pack_sum[DATA_W-1:0];
  end

  always_comb begin
    case (chan_e'(s2_chan))
      CH_CUR:  result = cur_res;
      CH_PACK: result = pack_res;
      default: result = s2_value;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_value <= '0;
      last_cur  <= '0;
    end else begin
      out_valid <= s2_valid;
      out_chan  <= s2_chan;
      out_value <= result;
      if (s2_valid && s2_chan == CH_CUR) last_cur <= cur_res;
    end
  end
endmodule

// File: rtl/meas_corrector.sv
module meas_corrector #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16,
  parameter int RES_W  = 16,
  parameter int NCELL  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [2:0]               in_chan,
  input  logic [DATA_W-1:0]        in_raw,
  input  logic [DATA_W-1:0]        cal_cur_off,
  input  logic [GAIN_W-1:0]        cal_cur_gain,
  input  logic [DATA_W-1:0]        cal_pack_off,
  input  logic [GAIN_W-1:0]        cal_pack_gain,
  input  logic [DATA_W-1:0]        cal_cell_off,
  input  logic [NCELL*GAIN_W-1:0]  cal_cell_gain,
  input  logic [DATA_W-1:0]        cal_tint_off,
  input  logic [GAIN_W-1:0]        cal_tint_gain,
  input  logic [DATA_W-1:0]        cal_text_off,
  input  logic [GAIN_W-1:0]        cal_text_gain,
  input  logic [DATA_W-1:0]        cal_null_band,
  input  logic [RES_W-1:0]         cal_pack_res,
  output logic                     out_valid,
  output logic [2:0]               out_chan,
  output logic [DATA_W-1:0]        out_value
);
  logic                     s1_valid;
  logic [2:0]               s1_chan;
  logic signed [DATA_W:0]   s1_diff;
  logic [GAIN_W-1:0]        s1_gain;
  logic                     s2_valid;
  logic [2:0]               s2_chan;
  logic signed [DATA_W-1:0] s2_value;

  mc_offset_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .NCELL(NCELL)) u_off (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_raw(in_raw),
    .cal_cur_off(cal_cur_off), .cal_cur_gain(cal_cur_gain),
    .cal_pack_off(cal_pack_off), .cal_pack_gain(cal_pack_gain),
    .cal_cell_off(cal_cell_off), .cal_cell_gain(cal_cell_gain),
    .cal_tint_off(cal_tint_off), .cal_tint_gain(cal_tint_gain),
    .cal_text_off(cal_text_off), .cal_text_gain(cal_text_gain),
    .s1_valid(s1_valid), .s1_chan(s1_chan), .s1_diff(s1_diff), .s1_gain(s1_gain)
  );

  mc_scale_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_chan(s1_chan),
    .s1_diff(s1_diff), .s1_gain(s1_gain),
    .s2_valid(s2_valid), .s2_chan(s2_chan), .s2_value(s2_value)
  );

  mc_post_stage #(.DATA_W(DATA_W), .RES_W(RES_W)) u_post (
    .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_chan(s2_chan),
    .s2_value(s2_value), .cal_null_band(cal_null_band), .cal_pack_res(cal_pack_res),
    .out_valid(out_valid), .out_chan(out_chan), .out_value(out_value)
  );
endmodule

// File: rtl/meas_corrector_chk.sv
module meas_corrector_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_chan,
  input logic              out_valid,
  input logic [2:0]        out_chan,
  input logic [DATA_W-1:0] out_value,
  input logic [DATA_W-1:0] cal_null_band
);
  // R1: no result on the clock after reset
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

  // R2: every accepted sample yields a result three clocks later
  a_r2_latency_fwd: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid);

  // R2: no result without a sample three clocks earlier
  a_r2_latency_back: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));

  // R2: the tag travels unchanged with its sample
  a_r2_tag_kept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_chan == $past(in_chan, 3));

  // R5: a nonzero current result is never inside the dead band
  a_r5_dead_band: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_chan == 3'd0 && out_value != '0) |->
      (($signed({out_value[DATA_W-1], out_value}) >= $signed({1'b0, cal_null_band})) ||
       ($signed({out_value[DATA_W-1], out_value}) <= -$signed({1'b0, cal_null_band}))));
endmodule

bind meas_corrector meas_corrector_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
  .out_valid(out_valid), .out_chan(out_chan), .out_value(out_value),
  .cal_null_band(cal_null_band)
);

// File: tb/meas_corrector_tb_top.sv
module meas_corrector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_chan = '0;
  logic [15:0] in_raw = '0;
  logic [15:0] cur_off, cur_gain, pack_off, pack_gain, cell_off;
  logic [63:0] cell_gain;
  logic [15:0] tint_off, tint_gain, text_off, text_gain, band, pres;
  logic out_valid;
  logic [2:0] out_chan;
  logic [15:0] out_value;

  always #10 clk = ~clk;

  meas_corrector dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_raw(in_raw),
    .cal_cur_off(cur_off), .cal_cur_gain(cur_gain),
    .cal_pack_off(pack_off), .cal_pack_gain(pack_gain),
    .cal_cell_off(cell_off), .cal_cell_gain(cell_gain),
    .cal_tint_off(tint_off), .cal_tint_gain(tint_gain),
    .cal_text_off(text_off), .cal_text_gain(text_gain),
    .cal_null_band(band), .cal_pack_res(pres),
    .out_valid(out_valid), .out_chan(out_chan), .out_value(out_value)
  );

  typedef struct {
    int   chan;
    int   value;
    int   cyc;
    string req;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  longint last_cur = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int expect_val(int ch, int raw);
    longint off, gain, v, d;
    case (ch)
      0: begin off = $signed(cur_off);  gain = cur_gain;  end
      1: begin off = $signed(pack_off); gain = pack_gain; end
      6: begin off = $signed(tint_off); gain = tint_gain; end
      7: begin off = $signed(text_off); gain = text_gain; end
      default: begin off = $signed(cell_off); gain = cell_gain[(ch-2)*16 +: 16]; end
    endcase
    v = sat16(((longint'(raw) - off) * gain) >>> 14);
    if (ch == 0) begin
      if (v < longint'(band) && v > -longint'(band)) v = 0;
      last_cur = v;
    end else if (ch == 1) begin
      d = (last_cur * longint'(pres)) / 65535;
      v = sat16(v + d);
    end
    return int'(v);
  endfunction

  task automatic send(int ch, int raw, string req);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_chan  = 3'(ch);
    in_raw   = 16'(raw);
    it.chan  = ch;
    it.value = expect_val(ch, raw);
    it.cyc   = cyc;
    it.req   = req;
    sb.push_back(it);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // monitor: pop and compare each result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        errors++; checks++;
        $display("FAIL R2: unexpected result actual=%0d expected=none", $signed(out_value));
      end else begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if ($signed(out_value) != it.value || out_chan != 3'(it.chan)) begin
          errors++;
          $display("FAIL %s: chan %0d actual=%0d/%0d expected=%0d/%0d", it.req, it.chan,
                   $signed(out_value), out_chan, it.value, it.chan);
        end
        checks++;
        if (cyc - it.cyc != 3) begin
          errors++;
          $display("FAIL R2: latency actual=%0d expected=3", cyc - it.cyc);
        end
      end
    end
  end

  initial begin
    cur_off = 16'd10; cur_gain = 16'd16384;
    pack_off = 16'hFFFB; pack_gain = 16'd24576;
    cell_off = 16'd3;
    cell_gain = {16'd20000, 16'd32768, 16'd8192, 16'd16384};
    tint_off = 16'd100; tint_gain = 16'd16384;
    text_off = 16'hFF38; text_gain = 16'd12000;
    band = 16'd3; pres = 16'd6553;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R1: out_valid actual=%0b expected=0", out_valid);
    end
    // R1: pack right after reset has no drop
    send(1, 2000, "R1");
    idle_drain();
    // R3: current and pack unity / 1.5 gain with offsets
    send(0, 1010, "R3"); send(0, -990, "R3"); send(1, 4000, "R3");
    send(1, -333, "R3");
    idle_drain();
    // R6: shared cell offset, separate gains; flooring with half gain
    send(2, 4003, "R6"); send(3, 4003, "R6"); send(3, -4, "R3_floor");
    send(4, 1203, "R6"); send(5, 3603, "R6");
    idle_drain();
    // R7: temperature pairs
    send(6, 2500, "R7"); send(7, 2500, "R7"); send(7, -1000, "R7");
    idle_drain();
    // R8: pack drop after positive and negative current, back to back
    send(0, 5010, "R8"); send(1, 3000, "R8");
    send(0, -7777, "R8"); send(1, 3000, "R8");
    send(0, 12, "R8"); send(1, 3000, "R8");
    idle_drain();
    // R5: dead band edges
    band = 16'd50;
    send(0, 59, "R5"); send(0, 60, "R5"); send(0, -40, "R5");
    send(0, -39, "R5"); send(0, 10, "R5");
    idle_drain();
    // R4: saturation
    cur_gain = 16'd65535; pack_gain = 16'd65535; pres = 16'd65535;
    send(0, 20000, "R4"); send(0, -30000, "R4");
    send(0, 32000, "R4"); send(1, 32000, "R4");
    idle_drain();
    // R2: mixed stream one per clock
    cur_gain = 16'd16384; pack_gain = 16'd16384; pres = 16'd1000;
    for (int i = 0; i < 24; i++) send(i % 8, i * 517 - 6000, "R2");
    idle_drain();
    checks++;
    if (sb.size() != 0) begin
      errors++; $display("FAIL R2: pending actual=%0d expected=0", sb.size());
    end
    done = 1;
  end

  initial begin
    while (!done && cyc < 20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2: watchdog actual=%0d cycles expected=completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule